// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This block sits beside a small 8-bit processor core and decides when and where the core jumps to service a peripheral interrupt. Each peripheral source owns one pending bit. A single-cycle raise strobe sets the bit and a single-cycle clear strobe removes it. At the end of every instruction step the core pulses a step strobe. On that strobe the unit filters the pending set, picks a winner and, when the global interrupt enable is set, issues a one-cycle vectoring command. The command carries the PC to push, the number of bytes to push and the new PC. The core must clear its enable flag when it sees the command.

Eligibility depends on the core state. While the core sleeps, a source can win only if its fixed wake mask shares at least one bit with the current sleep-mode code. While the core is awake, every pending source can win. Among the eligible sources, the lowest source index wins, because it has the lowest vector address. Source 0 is the reset vector. When it wins, the unit asks the core to reset and drops every pending request. The step that ends a return-from-interrupt instruction is not arbitrated, so the interrupted program always gets at least one instruction in between.

Top module: `irq_vector_unit`

## Requirements
- R1: Each source holds one pending bit. A raise sets it and a clear without a raise resets it. Raising a source that is already pending changes nothing, so a single acceptance empties it.
- R2: When a raise and a clear (or an acceptance) of the same source fall in one cycle, the raise wins and the bit is pending afterwards.
- R3: Among the eligible pending sources, the one with the lowest index (lowest vector address) wins.
- R4: When `asleep_i` is 1, source k is eligible only if bits [3k+2:3k] of `WAKE_MASKS` AND `sleep_mode_i` is nonzero. When `asleep_i` is 0, every pending source is eligible.
- R5: A winner with index above 0 and `iflag_i`=1 produces `take_irq_o`=1 in the cycle after the step strobe. In that cycle `push_pc_o` equals the `cur_pc_i` sampled with the strobe, `irq_idx_o` is the winner and `push_bytes_o` is ceil(PC_W/8).
- R6: On acceptance, `new_pc_o` = winner index × `SLOT_WORDS` + `vec_base_i`.
- R7: The accepted source's pending bit clears on the same edge that raises `take_irq_o`. Other pending bits stay set.
- R8: If `iflag_i` is 0, a non-reset winner produces no command and stays pending.
- R9: If the winner is index 0, `core_reset_o` pulses for one cycle whatever `iflag_i` is. In that cycle `new_pc_o`=0, `irq_idx_o`=0 and `take_irq_o`=0, and every pending bit not raised in that same cycle is cleared.
- R10: A step strobe with `last_reti_i`=1 performs no arbitration: no command, no reset, no pending change.
- R11: Arbitration happens only on a step strobe. Pending requests alone never produce a command.
- R12: After reset, `take_irq_o`, `core_reset_o`, `irq_idx_o`, `push_pc_o` and `new_pc_o` are all 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | NSRC | Per-source raise strobes |
| clear_i | input | NSRC | Per-source clear strobes |
| step_done_i | input | 1 | End of an instruction step; arbitrate now |
| last_reti_i | input | 1 | The step just ended was a return-from-interrupt |
| asleep_i | input | 1 | Core is in the sleep state |
| sleep_mode_i | input | MODE_W | Current sleep-mode code |
| iflag_i | input | 1 | Global interrupt enable flag |
| cur_pc_i | input | PC_W | Current program counter |
| vec_base_i | input | PC_W | Vector table offset |
| take_irq_o | output | 1 | One-cycle vectoring command |
| core_reset_o | output | 1 | One-cycle reset request (reset vector won) |
| irq_idx_o | output | clog2(NSRC) | Index of the accepted source |
| push_pc_o | output | PC_W | PC value the core pushes |
| new_pc_o | output | PC_W | PC value the core loads |
| push_bytes_o | output | 2 | Number of bytes to push |

## Verification
The bench sweeps every pending pattern of eight sources against every sleep mode, the awake state and both enable values. It compares the complete output tuple with a value computed from the wake masks. A priority encoder that picks the highest index, or a mask filter that is also applied while awake, shows up there as a wrong index or as a spurious command. Directed sequences then probe the state that persists between steps. A unit that cleared every pending bit on acceptance would lose the second request. One that let a clear beat a raise would drop an interrupt. One that arbitrated right after a return, or that vectored with the enable flag clear, would issue a command the bench does not expect. A reset vector that left other requests pending would issue a command on the following step.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_TAKE  = 2'd1,
    ACT_RESET = 2'd2
  } irqv_act_e;

endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raise_i,
  input  logic [NSRC-1:0] clear_i,
  input  logic [NSRC-1:0] consume_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  // raise has priority over clear and over consumption by the arbiter
  always_comb begin
    pend_d = (pend_q & ~clear_i & ~consume_i) | raise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_RAISE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i != '0) |=> (($past(raise_i) & ~pend_q) == '0)); // R2

endmodule

// File: rtl/irqv_eligible.sv
module irqv_eligible #(
  parameter int                      NSRC       = 8,
  parameter int                      MODE_W     = 3,
  parameter logic [NSRC*MODE_W-1:0]  WAKE_MASKS = '1
) (
  input  logic [NSRC-1:0]   pend_i,
  input  logic              asleep_i,
  input  logic [MODE_W-1:0] sleep_mode_i,
  output logic [NSRC-1:0]   elig_o
);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam logic [MODE_W-1:0] MASK_K = WAKE_MASKS[k*MODE_W +: MODE_W];
    logic wakes;
    assign wakes     = |(MASK_K & sleep_mode_i);
    assign elig_o[k] = pend_i[k] & (~asleep_i | wakes);
  end

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NSRC-1:0]  grant_o
);

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (any_o) begin
      grant_o[idx_o] = 1'b1;
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int                     NSRC       = 8,
  parameter int                     MODE_W     = 3,
  parameter int                     PC_W       = 16,
  parameter int                     SLOT_WORDS = 1,
  parameter logic [NSRC*MODE_W-1:0] WAKE_MASKS = 24'hA3388F
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         raise_i,
  input  logic [NSRC-1:0]         clear_i,
  input  logic                    step_done_i,
  input  logic                    last_reti_i,
  input  logic                    asleep_i,
  input  logic [MODE_W-1:0]       sleep_mode_i,
  input  logic                    iflag_i,
  input  logic [PC_W-1:0]         cur_pc_i,
  input  logic [PC_W-1:0]         vec_base_i,
  output logic                    take_irq_o,
  output logic                    core_reset_o,
  output logic [$clog2(NSRC)-1:0] irq_idx_o,
  output logic [PC_W-1:0]         push_pc_o,
  output logic [PC_W-1:0]         new_pc_o,
  output logic [1:0]              push_bytes_o
);

  import irqv_pkg::*;

  localparam int IDX_W    = $clog2(NSRC);
  localparam int PC_BYTES = (PC_W + 7) / 8;

  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  grant;
  logic [NSRC-1:0]  consume;
  logic             any_elig;
  logic [IDX_W-1:0] win_idx;
  logic [PC_W-1:0]  slot_addr;
  logic [PC_W-1:0]  vec_addr;
  logic             arb_en;
  irqv_act_e        act;
  logic             upd_en;

  logic             take_q,  take_d;
  logic             rst_q,   rst_d;
  logic [IDX_W-1:0] idx_q,   idx_d;
  logic [PC_W-1:0]  push_q,  push_d;
  logic [PC_W-1:0]  npc_q,   npc_d;

  irqv_pending #(.NSRC(NSRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_i   (raise_i),
    .clear_i   (clear_i),
    .consume_i (consume),
    .pend_o    (pend)
  );

  irqv_eligible #(.NSRC(NSRC), .MODE_W(MODE_W), .WAKE_MASKS(WAKE_MASKS)) u_elig (
    .pend_i       (pend),
    .asleep_i     (asleep_i),
    .sleep_mode_i (sleep_mode_i),
    .elig_o       (elig)
  );

  irqv_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
    .req_i   (elig),
    .any_o   (any_elig),
    .idx_o   (win_idx),
    .grant_o (grant)
  );

  // vector word address = index * slot size
  if (SLOT_WORDS == 2) begin : g_slot2
    assign slot_addr = PC_W'({win_idx, 1'b0});
  end else begin : g_slot1
    assign slot_addr = PC_W'(win_idx);
  end

  assign vec_addr = slot_addr + vec_base_i;
  assign arb_en   = step_done_i & ~last_reti_i;

  always_comb begin
    act = ACT_NONE;
    if (arb_en && any_elig) begin
      if (win_idx == '0) begin
        act = ACT_RESET;
      end else if (iflag_i) begin
        act = ACT_TAKE;
      end
    end
  end

  always_comb begin
    unique case (act)
      ACT_TAKE:  consume = grant;
      ACT_RESET: consume = '1;
      default:   consume = '0;
    endcase
  end

  // next-state for the command registers
  always_comb begin
    upd_en = (act != ACT_NONE);
    take_d = (act == ACT_TAKE);
    rst_d  = (act == ACT_RESET);
    idx_d  = idx_q;
    push_d = push_q;
    npc_d  = npc_q;
    if (act == ACT_TAKE) begin
      idx_d  = win_idx;
      push_d = cur_pc_i;
      npc_d  = vec_addr;
    end else if (act == ACT_RESET) begin
      idx_d  = '0;
      npc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      rst_q  <= 1'b0;
      idx_q  <= '0;
      push_q <= '0;
      npc_q  <= '0;
    end else begin
      take_q <= take_d;
      rst_q  <= rst_d;
      if (upd_en) begin
        idx_q  <= idx_d;
        push_q <= push_d;
        npc_q  <= npc_d;
      end
    end
  end

  assign take_irq_o   = take_q;
  assign core_reset_o = rst_q;
  assign irq_idx_o    = idx_q;
  assign push_pc_o    = push_q;
  assign new_pc_o     = npc_q;
  assign push_bytes_o = 2'(PC_BYTES);

  // copy of the previous raise strobes, used by the checks below
  logic [NSRC-1:0] raise_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raise_prev <= '0;
    end else begin
      raise_prev <= raise_i;
    end
  end

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_irq_o && core_reset_o)); // R9

  AST_TAKE_NEEDS_IFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> $past(iflag_i)); // R8

  AST_ACT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq_o || core_reset_o) |-> $past(step_done_i)); // R11

  AST_RETI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done_i && last_reti_i) |=> (!take_irq_o && !core_reset_o)); // R10

  AST_PUSH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> (push_pc_o == $past(cur_pc_i))); // R5

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> (pend[irq_idx_o] == raise_prev[irq_idx_o])); // R7

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_o |-> (((pend & ~raise_prev) == '0) && (new_pc_o == '0))); // R9

endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;

  localparam int          NSRC = 8;
  localparam int          MW   = 3;
  localparam int          PCW  = 16;
  localparam int          SLOT = 2;
  localparam logic [23:0] WM   = 24'hA3388F;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     raise, clear;
  logic           step_done, last_reti, asleep, iflag;
  logic [2:0]     smode;
  logic [15:0]    cur_pc, vbase;
  logic           take, creset;
  logic [2:0]     idx;
  logic [15:0]    push_pc, new_pc;
  logic [1:0]     pbytes;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  irq_vector_unit #(.NSRC(NSRC), .MODE_W(MW), .PC_W(PCW), .SLOT_WORDS(SLOT),
                    .WAKE_MASKS(WM)) u_irq_vector_unit (
    .clk(clk), .rst_n(rst_n), .raise_i(raise), .clear_i(clear),
    .step_done_i(step_done), .last_reti_i(last_reti), .asleep_i(asleep),
    .sleep_mode_i(smode), .iflag_i(iflag), .cur_pc_i(cur_pc),
    .vec_base_i(vbase), .take_irq_o(take), .core_reset_o(creset),
    .irq_idx_o(idx), .push_pc_o(push_pc), .new_pc_o(new_pc),
    .push_bytes_o(pbytes)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic raise_v(input logic [7:0] v);
    @(negedge clk); raise = v;
    @(negedge clk); raise = '0;
  endtask

  task automatic step(input logic reti);
    @(negedge clk); step_done = 1'b1; last_reti = reti;
    @(negedge clk); step_done = 1'b0; last_reti = 1'b0;
  endtask

  function automatic logic [36:0] pack_out();
    return {take, creset, idx, new_pc, push_pc};
  endfunction

  // expected output tuple after one step strobe from a clean reset
  function automatic logic [36:0] model(input logic [7:0] pat, input logic slp,
                                        input logic [2:0] md, input logic ien,
                                        input logic [15:0] pc, input logic [15:0] base);
    logic [7:0] el;
    int w;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m;
      m = WM[i*3 +: 3];
      el[i] = pat[i] & (!slp || ((m & md) != 3'd0));
    end
    w = -1;
    for (int i = 7; i >= 0; i--) if (el[i]) w = i;
    if (w < 0) return '0;
    if (w == 0) return {1'b0, 1'b1, 3'd0, 16'd0, 16'd0};
    if (!ien) return '0;
    return {1'b1, 1'b0, 3'(w), 16'(w * SLOT) + base, pc};
  endfunction

  task automatic expect_take(input string tag, input int w);
    check(tag, {61'd0, take, creset, 1'b0}, {61'd0, 1'b1, 1'b0, 1'b0});
    check(tag, {61'd0, idx}, 64'(w));
    check(tag, {48'd0, new_pc}, {48'd0, 16'(w * SLOT) + vbase});
  endtask

  task automatic expect_none(input string tag);
    check(tag, {62'd0, take, creset}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; raise = '0; clear = '0; step_done = 1'b0; last_reti = 1'b0;
    asleep = 1'b0; iflag = 1'b0; smode = '0; cur_pc = '0; vbase = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    check("R12 reset outputs", {27'd0, pack_out()}, 64'd0);
    check("R5 push byte count", {62'd0, pbytes}, 64'd2);

    // R3 R4 R5 R6 R8 R9 sweep of pending pattern x sleep mode x enable
    vbase = 16'h0200;
    for (int pat = 0; pat < 256; pat++) begin
      for (int sl = 0; sl < 9; sl++) begin
        for (int ib = 0; ib < 2; ib++) begin
          do_reset();
          raise_v(8'(pat));
          asleep = (sl < 8);
          smode  = 3'(sl);
          iflag  = ib[0];
          cur_pc = {8'(pat), 8'h3C};
          step(1'b0);
          check($sformatf("R3/R4/R5/R6/R8/R9 pat=%0d sl=%0d i=%0d", pat, sl, ib),
                {27'd0, pack_out()},
                {27'd0, model(8'(pat), asleep, smode, iflag, cur_pc, vbase)});
        end
      end
    end

    asleep = 1'b0; smode = '0; iflag = 1'b1; vbase = 16'h0040; cur_pc = 16'h1234;

    // R11 no arbitration without step strobe
    do_reset();
    raise_v(8'h08);
    repeat (4) @(negedge clk);
    expect_none("R11 no step no command");
    step(1'b0);
    expect_take("R11 step takes source 3", 3);
    check("R5 push pc", {48'd0, push_pc}, 64'h1234);
    @(negedge clk);
    expect_none("R5 command lasts one cycle");

    // R7 only the accepted bit clears
    do_reset();
    raise_v(8'h24);
    step(1'b0); expect_take("R7 first winner", 2);
    step(1'b0); expect_take("R7 other source kept", 5);
    step(1'b0); expect_none("R7 set emptied");

    // R1 duplicate raise and clear
    do_reset();
    raise_v(8'h10); raise_v(8'h10);
    step(1'b0); expect_take("R1 duplicate raise", 4);
    step(1'b0); expect_none("R1 single pending bit");
    raise_v(8'h40);
    @(negedge clk); clear = 8'h40;
    @(negedge clk); clear = '0;
    step(1'b0); expect_none("R1 clear removes request");

    // R2 raise beats clear, raise beats acceptance
    do_reset();
    @(negedge clk); raise = 8'h08; clear = 8'h08;
    @(negedge clk); raise = '0; clear = '0;
    step(1'b0); expect_take("R2 raise beats clear", 3);
    do_reset();
    raise_v(8'h20);
    @(negedge clk); step_done = 1'b1; raise = 8'h20;
    @(negedge clk); step_done = 1'b0; raise = '0;
    expect_take("R2 accept with raise", 5);
    step(1'b0); expect_take("R2 raise during accept survives", 5);

    // R8 enable clear keeps the request pending
    do_reset();
    raise_v(8'h08);
    iflag = 1'b0;
    step(1'b0); expect_none("R8 enable clear");
    iflag = 1'b1;
    step(1'b0); expect_take("R8 still pending", 3);

    // R10 no arbitration after return
    do_reset();
    raise_v(8'h02);
    step(1'b1); expect_none("R10 step after return");
    step(1'b0); expect_take("R10 next step takes", 1);

    // R9 reset vector flushes all
    do_reset();
    raise_v(8'h25);
    iflag = 1'b0;
    step(1'b0);
    check("R9 reset pulse", {27'd0, pack_out()}, {27'd0, 1'b0, 1'b1, 3'd0, 16'd0, 16'd0});
    iflag = 1'b1;
    step(1'b0); expect_none("R9 pending flushed");

    // R4 sleeping source not eligible, then wakes on awake
    do_reset();
    raise_v(8'h40);
    asleep = 1'b1; smode = 3'd7;
    step(1'b0); expect_none("R4 zero wake mask");
    asleep = 1'b0;
    step(1'b0); expect_take("R4 awake eligible", 6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule